// File: doc/BRIEF.md
# Request-Response Latency Deadline Monitor

This block watches two single-cycle pulse inputs, a request strobe and a response strobe, and judges whether every response arrives within a fixed time budget of the request it answers. The budget is given in nanoseconds together with the clock frequency, and the block turns it into a cycle count. When a request is seen, the monitor reads a free-running timestamp, adds the budget to it, and stores that absolute deadline in an in-order queue.

Each response is paired with the oldest outstanding deadline. The pair is judged on time when the arrival stamp is less than or equal to the deadline. If the head deadline passes with no response, the entry is retired as a timeout. A response that comes after that finds no stored request, so it is not credited to the expired one. Stamps are compared by modular subtraction, so the timestamp counter can wrap freely.

The block has per-transaction verdict pulses, the latency of the last matched pair, sticky error flags and event counters. A parameter selects pipelined operation (several requests outstanding) or single-outstanding operation (a second request while one is pending is a protocol error).

Top module: `latency_deadline_monitor`

## Requirements
- R1: The budget is B = CLK_FREQ_MHZ*BUDGET_NS/1000 cycles. A request sampled in cycle t followed by the matching response sampled in cycle u with u <= t+B gives a one-cycle pass_o pulse in cycle u+1.
- R2: A matching response sampled in cycle u = t+B+1 gives a one-cycle fail_o pulse in cycle u+1, with timeout_o low. pass_o and fail_o are never high together.
- R3: If no response is sampled up to cycle t+B, the entry is retired in cycle t+B+1, and fail_o and timeout_o both pulse in cycle t+B+2. A later response is then handled as unexpected (R8).
- R4: latency_o takes u-t for every matched pair (on time or late) in cycle u+1 and otherwise holds its value.
- R5: In pipelined mode (PIPELINED=1) responses are matched in order, oldest request first, with up to DEPTH requests outstanding.
- R6: In pipelined mode, a request that would leave more than DEPTH entries after this cycle's retirement is dropped and sets the sticky err_ovf_o.
- R7: In single mode (PIPELINED=0), a request while one entry stays pending after this cycle's retirement is dropped and sets the sticky err_proto_o.
- R8: A response with no stored request sets the sticky err_unexp_o and leaves the queue unchanged.
- R9: pass_cnt_o counts pass pulses and fail_cnt_o counts fail pulses. err_cnt_o counts dropped requests plus unexpected responses, and it adds 2 when both happen in one cycle.
- R10: A response or timeout that retires an entry frees its slot for a request in the same cycle. A response can never match a request sampled in the same cycle.
- R11: Verdicts stay correct across any number of wraps of the internal timestamp counter, which is TS_W = clog2(B+2)+1 bits wide.
- R12: A synchronous active-high reset clears the queue, every pulse, latency_o, the sticky flags and the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sync_i | input | 1 | Request strobe |
| ref_i | input | 1 | Response strobe |
| pass_o | output | 1 | Pulse: matched response on time |
| fail_o | output | 1 | Pulse: late match or timeout |
| timeout_o | output | 1 | Pulse: deadline expired without a response |
| latency_o | output | TS_W | Cycles between the last matched request and response |
| err_proto_o | output | 1 | Sticky: request while one is pending (single mode) |
| err_ovf_o | output | 1 | Sticky: request with the queue full (pipelined mode) |
| err_unexp_o | output | 1 | Sticky: response with nothing outstanding |
| pass_cnt_o | output | CNT_W | Count of pass pulses |
| fail_cnt_o | output | CNT_W | Count of fail pulses |
| err_cnt_o | output | CNT_W | Count of error events |

## Verification
Retirement and admission can fall in the same cycle. A response or an expiring head frees a slot at the moment a new request arrives, and a late response can land in the very cycle the head would otherwise time out. The bench provokes these cases by filling the queue and then strobing request and response together, and by placing responses exactly at t+B and t+B+1. A behavioural queue model run against a pipelined instance and a single-mode instance judges every output on every clock, including a long stretch of pseudo-random traffic that wraps the timestamp counter many times.

// File: rtl/mon_pkg.sv
package mon_pkg;
    typedef enum logic [1:0] {
        VERD_NONE    = 2'd0,
        VERD_PASS    = 2'd1,
        VERD_LATE    = 2'd2,
        VERD_TIMEOUT = 2'd3
    } verdict_e;

    function automatic int budget_cycles(input int freq_mhz, input int budget_ns);
        return (freq_mhz * budget_ns) / 1000;
    endfunction
endpackage

// File: rtl/mon_timebase.sv
module mon_timebase #(
    parameter int TS_W = 8
) (
    input  logic            clk_i,
    input  logic            rst_i,
    output logic [TS_W-1:0] ts_o
);
    logic [TS_W-1:0] ts_d, ts_q;

    always_comb begin
        ts_d = ts_q + TS_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ts_q <= '0;
        else       ts_q <= ts_d;
    end

    assign ts_o = ts_q;

    // R11: the stamp advances by exactly one per cycle, wrapping freely
    p_ts_step_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> ts_q == TS_W'($past(ts_q) + TS_W'(1)));
endmodule

// File: rtl/mon_deadline_fifo.sv
module mon_deadline_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             push_i,
    input  logic [W-1:0]     data_i,
    input  logic             pop_i,
    output logic [W-1:0]     head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             empty_o
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        count;
    } fifo_state_t;

    fifo_state_t st_d, st_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (pop_i) st_d.rd = bump(st_q.rd);
        if (push_i) begin
            st_d.mem[st_q.wr] = data_i;
            st_d.wr           = bump(st_q.wr);
        end
        st_d.count = st_q.count + CNT_W'(push_i) - CNT_W'(pop_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign head_o  = st_q.mem[st_q.rd];
    assign count_o = st_q.count;
    assign empty_o = (st_q.count == '0);

    p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        push_i |-> (int'(count_o) < DEPTH) || pop_i);
    p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        pop_i |-> !empty_o);
endmodule

// File: rtl/mon_verdict.sv
module mon_verdict #(
    parameter int TS_W   = 8,
    parameter int BUDGET = 10
) (
    input  logic            valid_i,
    input  logic [TS_W-1:0] ts_i,
    input  logic [TS_W-1:0] deadline_i,
    output logic            late_o,
    output logic [TS_W-1:0] latency_o
);
    logic [TS_W-1:0] diff;

    always_comb begin
        diff      = ts_i - deadline_i;
        late_o    = valid_i && (diff != '0) && !diff[TS_W-1];
        latency_o = TS_W'(BUDGET) + diff;
    end
endmodule

// File: rtl/latency_deadline_monitor.sv
module latency_deadline_monitor #(
    parameter int CLK_FREQ_MHZ = 200,
    parameter int BUDGET_NS    = 5000,
    parameter int DEPTH        = 4,
    parameter bit PIPELINED    = 1'b1,
    parameter int CNT_W        = 16,
    localparam int BUDGET  = mon_pkg::budget_cycles(CLK_FREQ_MHZ, BUDGET_NS),
    localparam int TS_W    = $clog2(BUDGET + 2) + 1,
    localparam int Q_DEPTH = PIPELINED ? DEPTH : 1,
    localparam int QC_W    = $clog2(Q_DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             sync_i,
    input  logic             ref_i,
    output logic             pass_o,
    output logic             fail_o,
    output logic             timeout_o,
    output logic [TS_W-1:0]  latency_o,
    output logic             err_proto_o,
    output logic             err_ovf_o,
    output logic             err_unexp_o,
    output logic [CNT_W-1:0] pass_cnt_o,
    output logic [CNT_W-1:0] fail_cnt_o,
    output logic [CNT_W-1:0] err_cnt_o
);
    import mon_pkg::*;

    typedef struct packed {
        logic             pass;
        logic             fail;
        logic             timeout;
        logic [TS_W-1:0]  lat;
        logic             e_proto;
        logic             e_ovf;
        logic             e_unexp;
        logic [CNT_W-1:0] n_pass;
        logic [CNT_W-1:0] n_fail;
        logic [CNT_W-1:0] n_err;
    } mon_state_t;

    mon_state_t st_d, st_q;

    logic [TS_W-1:0] ts_now, head_dl, pair_lat;
    logic [QC_W-1:0] q_count;
    logic            q_empty, head_late, q_pop, q_push;
    logic            unexp, reject;
    verdict_e        verdict;

    mon_timebase #(.TS_W(TS_W)) u_timebase (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .ts_o  (ts_now)
    );

    mon_deadline_fifo #(.DEPTH(Q_DEPTH), .W(TS_W)) u_queue (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .push_i  (q_push),
        .data_i  (ts_now + TS_W'(BUDGET)),
        .pop_i   (q_pop),
        .head_o  (head_dl),
        .count_o (q_count),
        .empty_o (q_empty)
    );

    mon_verdict #(.TS_W(TS_W), .BUDGET(BUDGET)) u_verdict (
        .valid_i    (!q_empty),
        .ts_i       (ts_now),
        .deadline_i (head_dl),
        .late_o     (head_late),
        .latency_o  (pair_lat)
    );

    always_comb begin
        if (ref_i && !q_empty)  verdict = head_late ? VERD_LATE : VERD_PASS;
        else if (head_late)     verdict = VERD_TIMEOUT;
        else                    verdict = VERD_NONE;

        q_pop  = (verdict != VERD_NONE);
        q_push = sync_i && ((int'(q_count) - int'(q_pop)) < Q_DEPTH);
        reject = sync_i && !q_push;
        unexp  = ref_i && q_empty;

        st_d         = st_q;
        st_d.pass    = (verdict == VERD_PASS);
        st_d.fail    = (verdict == VERD_LATE) || (verdict == VERD_TIMEOUT);
        st_d.timeout = (verdict == VERD_TIMEOUT);
        if (verdict == VERD_PASS || verdict == VERD_LATE) st_d.lat = pair_lat;
        if (reject) begin
            if (PIPELINED) st_d.e_ovf   = 1'b1;
            else           st_d.e_proto = 1'b1;
        end
        if (unexp) st_d.e_unexp = 1'b1;
        st_d.n_pass = st_q.n_pass + CNT_W'(st_d.pass);
        st_d.n_fail = st_q.n_fail + CNT_W'(st_d.fail);
        st_d.n_err  = st_q.n_err + CNT_W'(reject) + CNT_W'(unexp);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign pass_o      = st_q.pass;
    assign fail_o      = st_q.fail;
    assign timeout_o   = st_q.timeout;
    assign latency_o   = st_q.lat;
    assign err_proto_o = st_q.e_proto;
    assign err_ovf_o   = st_q.e_ovf;
    assign err_unexp_o = st_q.e_unexp;
    assign pass_cnt_o  = st_q.n_pass;
    assign fail_cnt_o  = st_q.n_fail;
    assign err_cnt_o   = st_q.n_err;

    p_pass_fail_excl_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !(pass_o && fail_o));
    p_timeout_is_fail_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        timeout_o |-> fail_o);
    p_pass_latency_bound_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        pass_o |-> int'(latency_o) <= BUDGET);
    p_sticky_unexp_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        err_unexp_o |=> err_unexp_o);
    p_pass_count_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        pass_o && !$past(rst_i) |-> pass_cnt_o == CNT_W'($past(pass_cnt_o) + CNT_W'(1)));
    p_mode_flag_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        PIPELINED |-> !err_proto_o);
endmodule

// File: tb/latency_deadline_monitor_bench.sv
module deadline_ref_model #(
    parameter int B     = 10,
    parameter int LIMIT = 4,
    parameter bit SINGLE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic rsp,
    output int   e_pass,
    output int   e_fail,
    output int   e_tmo,
    output int   e_lat,
    output int   e_proto,
    output int   e_ovf,
    output int   e_unexp,
    output int   e_npass,
    output int   e_nfail,
    output int   e_nerr
);
    int now;
    int dq[$];
    int sq[$];

    always @(posedge clk) begin
        if (rst) begin
            now = 0; dq.delete(); sq.delete();
            e_pass = 0; e_fail = 0; e_tmo = 0; e_lat = 0;
            e_proto = 0; e_ovf = 0; e_unexp = 0;
            e_npass = 0; e_nfail = 0; e_nerr = 0;
        end else begin
            automatic bit late = (dq.size() > 0) && (now > dq[0]);
            e_pass = 0; e_fail = 0; e_tmo = 0;
            if (rsp) begin
                if (dq.size() > 0) begin
                    e_lat = now - sq[0];
                    if (late) e_fail = 1; else e_pass = 1;
                    void'(dq.pop_front()); void'(sq.pop_front());
                end else begin
                    e_unexp = 1; e_nerr++;
                end
            end else if (late) begin
                e_fail = 1; e_tmo = 1;
                void'(dq.pop_front()); void'(sq.pop_front());
            end
            if (req) begin
                if (dq.size() < LIMIT) begin
                    dq.push_back(now + B); sq.push_back(now);
                end else begin
                    if (SINGLE) e_proto = 1; else e_ovf = 1;
                    e_nerr++;
                end
            end
            e_npass += e_pass;
            e_nfail += e_fail;
            now++;
        end
    end
endmodule

module latency_deadline_monitor_bench;
    localparam int MHZ = 200;
    localparam int NS  = 50;
    localparam int B   = MHZ * NS / 1000;
    localparam int TW  = $clog2(B + 2) + 1;
    localparam int D   = 4;
    localparam int CW  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic rsp = 1'b0;
    always #2.5 clk = ~clk;

    logic          p_pass, p_fail, p_tmo, p_proto, p_ovf, p_unexp;
    logic [TW-1:0] p_lat;
    logic [CW-1:0] p_np, p_nf, p_ne;
    logic          s_pass, s_fail, s_tmo, s_proto, s_ovf, s_unexp;
    logic [TW-1:0] s_lat;
    logic [CW-1:0] s_np, s_nf, s_ne;

    latency_deadline_monitor #(.CLK_FREQ_MHZ(MHZ), .BUDGET_NS(NS), .DEPTH(D),
        .PIPELINED(1'b1), .CNT_W(CW)) u_latency_deadline_monitor (
        .clk_i(clk), .rst_i(rst), .sync_i(req), .ref_i(rsp),
        .pass_o(p_pass), .fail_o(p_fail), .timeout_o(p_tmo), .latency_o(p_lat),
        .err_proto_o(p_proto), .err_ovf_o(p_ovf), .err_unexp_o(p_unexp),
        .pass_cnt_o(p_np), .fail_cnt_o(p_nf), .err_cnt_o(p_ne));

    latency_deadline_monitor #(.CLK_FREQ_MHZ(MHZ), .BUDGET_NS(NS), .DEPTH(D),
        .PIPELINED(1'b0), .CNT_W(CW)) u_latency_deadline_monitor_single (
        .clk_i(clk), .rst_i(rst), .sync_i(req), .ref_i(rsp),
        .pass_o(s_pass), .fail_o(s_fail), .timeout_o(s_tmo), .latency_o(s_lat),
        .err_proto_o(s_proto), .err_ovf_o(s_ovf), .err_unexp_o(s_unexp),
        .pass_cnt_o(s_np), .fail_cnt_o(s_nf), .err_cnt_o(s_ne));

    int mp_pass, mp_fail, mp_tmo, mp_lat, mp_proto, mp_ovf, mp_unexp, mp_np, mp_nf, mp_ne;
    int ms_pass, ms_fail, ms_tmo, ms_lat, ms_proto, ms_ovf, ms_unexp, ms_np, ms_nf, ms_ne;

    deadline_ref_model #(.B(B), .LIMIT(D), .SINGLE(1'b0)) u_model_pipe (
        .clk(clk), .rst(rst), .req(req), .rsp(rsp),
        .e_pass(mp_pass), .e_fail(mp_fail), .e_tmo(mp_tmo), .e_lat(mp_lat),
        .e_proto(mp_proto), .e_ovf(mp_ovf), .e_unexp(mp_unexp),
        .e_npass(mp_np), .e_nfail(mp_nf), .e_nerr(mp_ne));

    deadline_ref_model #(.B(B), .LIMIT(1), .SINGLE(1'b1)) u_model_single (
        .clk(clk), .rst(rst), .req(req), .rsp(rsp),
        .e_pass(ms_pass), .e_fail(ms_fail), .e_tmo(ms_tmo), .e_lat(ms_lat),
        .e_proto(ms_proto), .e_ovf(ms_ovf), .e_unexp(ms_unexp),
        .e_npass(ms_np), .e_nfail(ms_nf), .e_nerr(ms_ne));

    int    checks = 0;
    int    failures = 0;
    bit    started = 1'b0;
    bit    done = 1'b0;
    string phase = "R12";

    task automatic chk(input string req_tag, input string inst, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s (%s, phase %s) actual=%0d expected=%0d", req_tag, inst, phase, act, exp);
        end
    endtask

    always @(posedge clk) started <= 1'b1;

    always @(negedge clk) begin
        if (started && !done) begin
            chk("R1",  "pipe", int'(p_pass),  mp_pass);
            chk("R2",  "pipe", int'(p_fail),  mp_fail);
            chk("R3",  "pipe", int'(p_tmo),   mp_tmo);
            chk("R4",  "pipe", int'(p_lat),   mp_lat);
            chk("R6",  "pipe", int'(p_ovf),   mp_ovf);
            chk("R7",  "pipe", int'(p_proto), mp_proto);
            chk("R8",  "pipe", int'(p_unexp), mp_unexp);
            chk("R9",  "pipe", int'(p_np),    mp_np);
            chk("R9",  "pipe", int'(p_nf),    mp_nf);
            chk("R9",  "pipe", int'(p_ne),    mp_ne);
            chk("R1",  "single", int'(s_pass),  ms_pass);
            chk("R2",  "single", int'(s_fail),  ms_fail);
            chk("R3",  "single", int'(s_tmo),   ms_tmo);
            chk("R4",  "single", int'(s_lat),   ms_lat);
            chk("R7",  "single", int'(s_proto), ms_proto);
            chk("R6",  "single", int'(s_ovf),   ms_ovf);
            chk("R8",  "single", int'(s_unexp), ms_unexp);
            chk("R9",  "single", int'(s_np),    ms_np);
            chk("R9",  "single", int'(s_nf),    ms_nf);
            chk("R9",  "single", int'(s_ne),    ms_ne);
        end
    end

    task automatic cyc(input bit q, input bit r);
        @(negedge clk);
        req = q;
        rsp = r;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired in phase %s", phase);
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk) rst = 1'b0;
        // R12: reset state, all outputs zero
        phase = "R12";
        chk("R12", "pipe", int'(p_pass | p_fail | p_tmo | p_ovf | p_unexp), 0);
        chk("R12", "pipe", int'(p_np) + int'(p_nf) + int'(p_ne) + int'(p_lat), 0);
        chk("R12", "single", int'(s_proto | s_pass) + int'(s_ne), 0);
        // R1: response exactly at t+B passes
        phase = "R1";
        cyc(1, 0); idle(B - 1); cyc(0, 1); idle(3);
        chk("R1", "pipe", int'(p_np), 1);
        chk("R4", "pipe", int'(p_lat), B);
        // R2: response at t+B+1 is a late match
        phase = "R2";
        cyc(1, 0); idle(B); cyc(0, 1); idle(3);
        chk("R2", "pipe", int'(p_nf), 1);
        // R3 then R8: timeout retires, later response unexpected
        phase = "R3";
        cyc(1, 0); idle(B + 4); cyc(0, 1); idle(2);
        chk("R8", "pipe", int'(p_unexp), 1);
        // R5: several outstanding, matched oldest first
        phase = "R5";
        cyc(1, 0); cyc(1, 0); cyc(1, 0); idle(2);
        cyc(0, 1); idle(1); cyc(0, 1); cyc(0, 1); idle(B + 3);
        // R6, R7: overflow in pipelined, protocol error in single
        phase = "R6";
        for (int i = 0; i < D + 2; i++) cyc(1, 0);
        // R10: retirement and request in same cycle
        phase = "R10";
        cyc(1, 1); cyc(1, 1); idle(2); cyc(0, 1); cyc(1, 1);
        idle(B + 3);
        // R10: timeout expiring while a new request arrives
        cyc(1, 0); idle(B); cyc(1, 0); idle(B + 3);
        phase = "R7";
        cyc(1, 0); cyc(1, 0); idle(B + 3);
        // R11: pseudo-random traffic wrapping the stamp counter many times
        phase = "R11";
        for (int i = 0; i < 600; i++) cyc($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
        idle(B + 3);
        // R12: reset mid-run clears everything
        phase = "R12";
        cyc(1, 0); cyc(0, 0);
        @(negedge clk) rst = 1'b1;
        idle(2);
        @(negedge clk) rst = 1'b0;
        chk("R12", "pipe", int'(p_np) + int'(p_nf) + int'(p_ne), 0);
        chk("R12", "pipe", int'(p_ovf | p_unexp | p_pass | p_fail), 0);
        idle(B + 4);
        chk("R12", "pipe", int'(p_tmo | p_fail) + int'(p_nf), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule